// File: doc/BRIEF.md
# Mailbox Command Responder

This block sits behind a small word-addressed register window and acts as the command engine of a data-acquisition front end. A host places a subsystem code and up to eight 16-bit parameters in their registers, then writes a command word into the mailbox register. The responder clears the status byte of that word, works for a fixed number of cycles, carries out the command against a few simple internal subsystems, and writes a completion code into the upper byte of the same mailbox word. It then raises a command-done interrupt flag.

The internal subsystems are kept deliberately small. An analog-out store keeps one value per channel. An analog-in path reads back the stored analog-out value of a channel, scaled by a gain shift. A digital-in path samples an input port, and a digital-out register drives an output port. A code-memory view returns a computed word for each address. A per-subsystem configuration word can be set and read back. Start, stop and halt are acknowledged and have no other effect.

Top module: `mbx_responder`

## Requirements
- R1: After synchronous reset every register word reads 0x0000, `dout` is 0 and `cmd_done_irq` is 0.
- R2: The register map is: parameters 0..7 at words 0..7, subsystem code at word 8, mailbox at word 9, interrupt flags at word 10, and any other word reads 0. `host_rdata` shows the word addressed one clock earlier. A write to word 9 stores the command code in bits 7:0 and clears the status byte (bits 15:8) to 0x00.
- R3: The status byte stays 0x00 while a command runs. It changes exactly once, EXEC_CYCLES clocks after the command write, to 0x55 (success), 0xAA (error) or 0xFF (unsupported), and holds that value until the next command. This is well inside 100 host polls.
- R4: A command code other than 0, 1, 2, 3, 4, 5, 6, 37 and 48 completes with 0xFF and leaves all parameters unchanged.
- R5: A known command with a subsystem code above 5 completes with 0xAA.
- R6: Read single (code 5) on analog in (subsystem 0) returns in parameter 2 the stored analog-out value of the channel in parameter 0, shifted left by parameter 1 bits 1:0 and truncated to 16 bits. A channel of NUM_CH or more completes with 0xAA and leaves parameter 2 unchanged.
- R7: Read single on digital in (subsystem 2) returns the `din` port in parameter 2.
- R8: Write single (code 6) on analog out (subsystem 1) stores parameter 2 for the channel in parameter 0. A channel of NUM_CH or more completes with 0xAA and stores nothing.
- R9: Write single on digital out (subsystem 3) drives parameter 2 onto `dout`.
- R10: Get board info (0) puts BOARD_ID into parameter 0. Configure (1) stores parameter 0 as the configuration word of the subsystem. Get configuration (2) returns that word in parameter 0. Start (3), stop (4) and halt (48) complete with 0x55.
- R11: Read code (37) on memory (subsystem 4) returns {p0[7:0], ~p0[7:0]} in parameter 2. Read code on any other subsystem, and read or write single on the counter subsystem (5), complete with 0xAA.
- R12: Bit 7 of word 10 and `cmd_done_irq` are set at completion. Writing word 10 with bit 7 high clears them.
- R13: A write to word 9 while a command runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register word address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Registered read data of the previously addressed word |
| din | input | 16 | Digital input port sampled by read single |
| dout | output | 16 | Digital output register |
| cmd_done_irq | output | 1 | Command-done interrupt flag |

## Verification
A wrong decode shows up as a bad status byte in the mailbox word within EXEC_CYCLES + 1 clocks of the command write. A stale or early status appears as a nonzero byte on the first poll, or as a 0x00 still present after completion. A corrupted analog-out store only shows when a later analog-in read returns the wrong scaled value, so every write is followed by a read-back. Errors in parameter handling are exposed by reading the parameter words back after rejected commands, to check that they are untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_SUB = 6;

  localparam logic [7:0] OP_INFO   = 8'd0;
  localparam logic [7:0] OP_CFG    = 8'd1;
  localparam logic [7:0] OP_GETCFG = 8'd2;
  localparam logic [7:0] OP_START  = 8'd3;
  localparam logic [7:0] OP_STOP   = 8'd4;
  localparam logic [7:0] OP_RDS    = 8'd5;
  localparam logic [7:0] OP_WRS    = 8'd6;
  localparam logic [7:0] OP_RDCODE = 8'd37;
  localparam logic [7:0] OP_HALT   = 8'd48;

  localparam logic [7:0] ST_PEND  = 8'h00;
  localparam logic [7:0] ST_OK    = 8'h55;
  localparam logic [7:0] ST_ERR   = 8'hAA;
  localparam logic [7:0] ST_UNSUP = 8'hFF;

  localparam logic [WORD_W-1:0] SS_AIN  = 16'd0;
  localparam logic [WORD_W-1:0] SS_AOUT = 16'd1;
  localparam logic [WORD_W-1:0] SS_DIN  = 16'd2;
  localparam logic [WORD_W-1:0] SS_DOUT = 16'd3;
  localparam logic [WORD_W-1:0] SS_MEM  = 16'd4;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_INFO, ACT_SETCFG, ACT_GETCFG, ACT_AIN_RD,
    ACT_DIN_RD, ACT_AOUT_WR, ACT_DOUT_WR, ACT_CODE_RD
  } act_e;

  typedef struct packed {
    logic [7:0] status;
    act_e       act;
  } verdict_t;
endpackage

// File: rtl/mbx_classify.sv
module mbx_classify
  import mbx_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [7:0]        op,
  input  logic [WORD_W-1:0] sub,
  input  logic [WORD_W-1:0] chan,
  output verdict_t          verdict
);
  logic known, sub_ok, chan_ok;

  always_comb begin
    known   = op inside {OP_INFO, OP_CFG, OP_GETCFG, OP_START, OP_STOP,
                         OP_RDS, OP_WRS, OP_RDCODE, OP_HALT};
    sub_ok  = sub < WORD_W'(NUM_SUB);
    chan_ok = chan < WORD_W'(NUM_CH);
    verdict.status = ST_ERR;
    verdict.act    = ACT_NONE;
    if (!known) begin
      verdict.status = ST_UNSUP;
    end else if (sub_ok) begin
      case (op)
        OP_INFO:   begin verdict.status = ST_OK; verdict.act = ACT_INFO;   end
        OP_CFG:    begin verdict.status = ST_OK; verdict.act = ACT_SETCFG; end
        OP_GETCFG: begin verdict.status = ST_OK; verdict.act = ACT_GETCFG; end
        OP_START, OP_STOP, OP_HALT: verdict.status = ST_OK;
        OP_RDS: begin
          if (sub == SS_AIN && chan_ok) begin
            verdict.status = ST_OK; verdict.act = ACT_AIN_RD;
          end else if (sub == SS_DIN) begin
            verdict.status = ST_OK; verdict.act = ACT_DIN_RD;
          end
        end
        OP_WRS: begin
          if (sub == SS_AOUT && chan_ok) begin
            verdict.status = ST_OK; verdict.act = ACT_AOUT_WR;
          end else if (sub == SS_DOUT) begin
            verdict.status = ST_OK; verdict.act = ACT_DOUT_WR;
          end
        end
        OP_RDCODE: begin
          if (sub == SS_MEM) begin
            verdict.status = ST_OK; verdict.act = ACT_CODE_RD;
          end
        end
        default: verdict.status = ST_UNSUP;
      endcase
    end
  end
endmodule

// File: rtl/mbx_busy_timer.sv
module mbx_busy_timer #(
  parameter int EXEC_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(EXEC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(EXEC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == LAST);
endmodule

// File: rtl/mbx_sample_ram.sv
module mbx_sample_ram #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int              NUM_PAR     = 8,
  parameter int              NUM_CH      = 4,
  parameter int              EXEC_CYCLES = 4,
  parameter int              MAX_BUSY    = 12500,
  parameter logic [15:0]     BOARD_ID    = 16'h3C01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic [15:0] din,
  output logic [15:0] dout,
  output logic        cmd_done_irq
);
  localparam int PAW       = $clog2(NUM_PAR);
  localparam int CHW       = $clog2(NUM_CH);
  localparam int SIW       = $clog2(NUM_SUB);
  localparam int CFG_SLOTS = 1 << SIW;
  localparam logic [3:0] A_SUB  = 4'(NUM_PAR);
  localparam logic [3:0] A_MBX  = 4'(NUM_PAR + 1);
  localparam logic [3:0] A_FLAG = 4'(NUM_PAR + 2);

  logic [WORD_W-1:0] par_q [NUM_PAR];
  logic [WORD_W-1:0] cfg_q [CFG_SLOTS];
  logic [WORD_W-1:0] sub_q, mbox_q, rd_mux, ram_q;
  logic              busy, done, cmd_go;
  verdict_t          verdict;

  assign cmd_go = host_we && (host_addr == A_MBX);

  mbx_busy_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(cmd_go), .busy(busy), .done(done)
  );

  mbx_classify #(.NUM_CH(NUM_CH)) u_classify (
    .op(mbox_q[7:0]), .sub(sub_q), .chan(par_q[0]), .verdict(verdict)
  );

  mbx_sample_ram #(.DEPTH(NUM_CH), .W(WORD_W)) u_aout (
    .clk(clk),
    .we(done && verdict.act == ACT_AOUT_WR),
    .waddr(par_q[0][CHW-1:0]),
    .wdata(par_q[2]),
    .raddr(par_q[0][CHW-1:0]),
    .rdata(ram_q)
  );

  always_comb begin
    rd_mux = '0;
    if (host_addr < A_SUB)       rd_mux = par_q[host_addr[PAW-1:0]];
    else if (host_addr == A_SUB) rd_mux = sub_q;
    else if (host_addr == A_MBX) rd_mux = mbox_q;
    else if (host_addr == A_FLAG) rd_mux[7] = cmd_done_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAR; i++)   par_q[i] <= '0;
      for (int i = 0; i < CFG_SLOTS; i++) cfg_q[i] <= '0;
      sub_q        <= '0;
      mbox_q       <= '0;
      host_rdata   <= '0;
      dout         <= '0;
      cmd_done_irq <= 1'b0;
    end else begin
      host_rdata <= rd_mux;
      if (host_we) begin
        if (host_addr < A_SUB)        par_q[host_addr[PAW-1:0]] <= host_wdata;
        else if (host_addr == A_SUB)  sub_q <= host_wdata;
        else if (host_addr == A_MBX && !busy) mbox_q <= {ST_PEND, host_wdata[7:0]};
        else if (host_addr == A_FLAG && host_wdata[7]) cmd_done_irq <= 1'b0;
      end
      if (done) begin
        mbox_q[15:8] <= verdict.status;
        cmd_done_irq <= 1'b1;
        case (verdict.act)
          ACT_INFO:    par_q[0] <= BOARD_ID;
          ACT_SETCFG:  cfg_q[sub_q[SIW-1:0]] <= par_q[0];
          ACT_GETCFG:  par_q[0] <= cfg_q[sub_q[SIW-1:0]];
          ACT_AIN_RD:  par_q[2] <= ram_q << par_q[1][1:0];
          ACT_DIN_RD:  par_q[2] <= din;
          ACT_DOUT_WR: dout     <= par_q[2];
          ACT_CODE_RD: par_q[2] <= {par_q[0][7:0], ~par_q[0][7:0]};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbx_responder_chk.sv
module mbx_responder_chk #(
  parameter int MAX_BUSY = 12500
) (
  input logic        clk,
  input logic        rst,
  input logic        host_we,
  input logic [3:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic [15:0] mbox,
  input logic        busy,
  input logic        irq
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= 0;
    else              busy_len <= busy_len + 1;
  end

  logic op_known;
  assign op_known = (mbox[7:0] <= 8'd6) || (mbox[7:0] == 8'd37) || (mbox[7:0] == 8'd48);

  // R2
  a_r2_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 4'd9 && !busy) |=>
      (mbox[15:8] == 8'h00 && mbox[7:0] == $past(host_wdata[7:0]) && busy));

  // R3
  a_r3_pending_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> mbox[15:8] == 8'h00);

  // R3
  a_r3_legal_status: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mbox[15:8] == 8'h00 || mbox[15:8] == 8'h55 ||
               mbox[15:8] == 8'hAA || mbox[15:8] == 8'hFF));

  // R3
  a_r3_time_limit: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_len < MAX_BUSY);

  // R12
  a_r12_flag_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (irq && mbox[15:8] != 8'h00));

  // R4
  a_r4_unknown_code: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !op_known) |-> mbox[15:8] == 8'hFF);

  // R13
  a_r13_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 4'd9 && busy) |=> $stable(mbox[7:0]));
endmodule

bind mbx_responder mbx_responder_chk #(.MAX_BUSY(MAX_BUSY)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .mbox(mbox_q), .busy(busy), .irq(cmd_done_irq)
);

// File: tb/mbx_responder_test.sv
`timescale 1ns/1ps
module mbx_responder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        cmd_done_irq;

  always #4 clk = ~clk;

  mbx_responder uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .din(din),
    .dout(dout), .cmd_done_irq(cmd_done_irq)
  );

  typedef struct {
    int          due;
    logic [3:0]  a;
    logic [15:0] v;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   vectors = 0;
  int   errors = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items in the cycle they fall due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      vectors++;
      if (host_rdata !== e.v) begin
        errors++;
        $display("FAIL %s: word %0d got %h expected %h", e.tag, e.a, host_rdata, e.v);
      end
    end
  end

  task automatic cmp(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [15:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    host_addr = a;
    e.due = cyc + 1; e.a = a; e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic poll_done(input string tag);
    int polls;
    polls = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      host_addr = 4'd9;
      @(negedge clk);
      polls++;
      if (host_rdata[15:8] != 8'h00) break;
    end
    cmp(16'(polls <= 100 && host_rdata[15:8] != 8'h00), 16'd1, tag);
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] st, input string tag);
    wr(4'd9, {8'hC3, op});
    chk(4'd9, {8'h00, op}, "R2 status cleared");
    poll_done("R3 completes within poll limit");
    chk(4'd9, {st, op}, tag);
  endtask

  task automatic setup(input logic [15:0] sub, input logic [15:0] p0,
                       input logic [15:0] p1, input logic [15:0] p2);
    wr(4'd8, sub); wr(4'd0, p0); wr(4'd1, p1); wr(4'd2, p2);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(4'd0, 16'h0000, "R1 param0 reset");
    chk(4'd9, 16'h0000, "R1 mailbox reset");
    chk(4'd10, 16'h0000, "R1 flags reset");
    chk(4'd14, 16'h0000, "R2 unmapped word");
    cmp(dout, 16'h0000, "R1 dout reset");
    cmp(16'(cmd_done_irq), 16'd0, "R1 irq reset");

    // R8 analog-out writes
    setup(16'd1, 16'd2, 16'd0, 16'h1234);
    issue(8'd6, 8'h55, "R8 write ch2");
    cmp(16'(cmd_done_irq), 16'd1, "R12 irq set");
    chk(4'd10, 16'h0080, "R12 flag word");
    wr(4'd10, 16'h0080);
    chk(4'd10, 16'h0000, "R12 flag cleared");
    cmp(16'(cmd_done_irq), 16'd0, "R12 irq cleared");
    setup(16'd1, 16'd1, 16'd0, 16'h0001);
    issue(8'd6, 8'h55, "R8 write ch1");
    setup(16'd1, 16'd5, 16'd0, 16'hFFFF);
    issue(8'd6, 8'hAA, "R8 channel out of range");

    // R6 analog-in read back with gain
    setup(16'd0, 16'd2, 16'd1, 16'h0000);
    issue(8'd5, 8'h55, "R6 read ch2");
    chk(4'd2, 16'h2468, "R6 gain 1");
    wr(4'd1, 16'd3);
    issue(8'd5, 8'h55, "R6 read ch2 gain3");
    chk(4'd2, 16'h91A0, "R6 gain 3");
    setup(16'd0, 16'd1, 16'd0, 16'h0000);
    issue(8'd5, 8'h55, "R8 ch1 not overwritten");
    chk(4'd2, 16'h0001, "R8 ch1 kept");
    setup(16'd0, 16'd4, 16'd0, 16'h7777);
    issue(8'd5, 8'hAA, "R6 channel out of range");
    chk(4'd2, 16'h7777, "R6 param2 untouched");

    // R7 digital in
    din = 16'hBEEF;
    setup(16'd2, 16'd0, 16'd0, 16'h0000);
    issue(8'd5, 8'h55, "R7 din read");
    chk(4'd2, 16'hBEEF, "R7 din value");

    // R9 digital out
    setup(16'd3, 16'd0, 16'd0, 16'h5A3C);
    issue(8'd6, 8'h55, "R9 dout write");
    cmp(dout, 16'h5A3C, "R9 dout value");

    // R10 board info and configuration
    setup(16'd0, 16'h0000, 16'd0, 16'h0000);
    issue(8'd0, 8'h55, "R10 board info");
    chk(4'd0, 16'h3C01, "R10 board id");
    setup(16'd3, 16'h00F0, 16'd0, 16'h0000);
    issue(8'd1, 8'h55, "R10 configure");
    wr(4'd0, 16'h0000);
    issue(8'd2, 8'h55, "R10 get config");
    chk(4'd0, 16'h00F0, "R10 config readback");
    wr(4'd8, 16'd2);
    issue(8'd2, 8'h55, "R10 get config other");
    chk(4'd0, 16'h0000, "R10 config per subsystem");
    issue(8'd48, 8'h55, "R10 halt");

    // R11 code memory and counter subsystem
    setup(16'd4, 16'h0012, 16'd1, 16'h0000);
    issue(8'd37, 8'h55, "R11 read code");
    chk(4'd2, 16'h12ED, "R11 code word");
    wr(4'd8, 16'd0);
    issue(8'd37, 8'hAA, "R11 read code wrong subsystem");
    wr(4'd8, 16'd5);
    issue(8'd5, 8'hAA, "R11 counter read single");

    // R4 unknown command
    setup(16'd0, 16'h1111, 16'd0, 16'h2222);
    issue(8'd7, 8'hFF, "R4 unknown code");
    chk(4'd0, 16'h1111, "R4 param0 untouched");
    chk(4'd2, 16'h2222, "R4 param2 untouched");

    // R5 bad subsystem
    wr(4'd8, 16'd9);
    issue(8'd3, 8'hAA, "R5 subsystem out of range");
    wr(4'd8, 16'd0);
    issue(8'd3, 8'h55, "R10 start");

    // R13 command write while busy
    wr(4'd9, 16'h0004);
    wr(4'd9, 16'h0007);
    poll_done("R13 completes");
    chk(4'd9, 16'h5504, "R13 second write ignored");

    repeat (4) @(negedge clk);
    finished = 1;
    report();
  end
endmodule